// File: doc/BRIEF.md
# Single-Cycle Eight-Register Processor Core

This block is a compact processor core that completes one instruction on every clock. It holds a 256-word program store of 32-bit words and a 256-byte data store. It has eight 8-bit register slots and a three-function arithmetic unit, and it computes the next program counter in the same cycle. The program is written through a load port while reset is held low. When reset is released the core starts fetching from address 0 and runs until it meets a halt instruction.

Two register slots are special. Slot 6 is a constant zero source, so moves and absolute addresses need no extra opcode. Slot 7 is the program counter itself: reading it gives the address of the executing instruction, and writing it makes a jump. The arithmetic result serves three purposes. It is the value written back to a register, it is the data-store address for loads and stores, and it is the target of a jump. A debug port reads any register slot and any data-store byte combinationally, so results can be inspected after a run.

Top module: `tc_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, the program counter, registers r0 to r5, the compare flag and the halted output are cleared. The program store is not touched by reset.
- R2: Each rising edge with reset high and the core not halted executes exactly one instruction. A non-jumping instruction advances the PC by one, and the PC wraps from 255 to 0. Opcodes 8 to 14 do nothing except advance the PC.
- R3: MOV writes Y to rd. ADD writes X+Y modulo 256 to rd. AND writes X AND Y to rd. X is the register chosen by rx. Y is the zero-extended imm when the immediate-select bit is 1, and otherwise the register chosen by ry.
- R4: Register slot 6 always reads as 0, and every write to it is discarded.
- R5: Register slot 7 reads as the address of the executing instruction. Any register write whose destination is slot 7 loads the written value into the PC, which acts as an unconditional jump.
- R6: LD writes the data-store byte at address X+Y to rd. ST writes register rd to the data-store byte at address X+Y.
- R7: CMP sets the compare flag to 1 when X+Y modulo 256 is zero, and clears it otherwise. CMP writes no register. Only CMP changes the flag.
- R8: JMP always loads X+Y into the PC. JE loads X+Y only when the compare flag is 1, and otherwise advances the PC by one.
- R9: HLT raises halted and keeps the PC on the HLT address. From then until reset, no register, flag or data-store write happens.
- R10: Instruction fields are as follows. Bits 31:28 hold the opcode (MOV 0, ADD 1, AND 2, CMP 3, JMP 4, JE 5, LD 6, ST 7, HLT 15). Bits 26:24 hold rd, bits 22:20 hold rx and bits 18:16 hold ry. Bit 8 selects the immediate, and bits 7:0 hold imm. Bits 27, 23, 19 and 15:9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_we | input | 1 | Write enable for the program store |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 32 | Instruction word to be written |
| halted | output | 1 | High once HLT has executed, until reset |
| dbg_reg_sel | input | 3 | Register slot to read on the debug port |
| dbg_reg_data | output | 8 | Value of the selected register slot (slot 7 gives the PC) |
| dbg_mem_addr | input | 8 | Data-store byte address to read on the debug port |
| dbg_mem_data | output | 8 | Data-store byte at dbg_mem_addr |

## Verification
The bench checks the edge cases one at a time.

- An 8-bit add that wraps to zero must give 0. A design that kept a carry would store a nonzero value and would leave the compare flag clear.
- A write to slot 6 must be dropped. A design that stored it would later hand a wrong base address to the store instruction.
- A move into slot 7 must act as a jump. A design that missed this would execute the skipped instruction and corrupt r1.
- JE is run after reset with a flag that was set before the reset. A design that did not clear the flag would take the branch.
- A program of nothing but undefined opcodes must walk the PC through 255 back to 0 without touching r0.
- After HLT, extra clocks are applied. A design that did not freeze would move the PC off the halt address.

// File: rtl/tc_pkg.sv
// Package tc_pkg
// Shared constants, opcode values and the decoded-instruction type for the
// tc_core processor. Assumes a fixed 32-bit instruction word.
package tc_pkg;
    localparam int INSTR_W  = 32;
    localparam int IMM_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int RIDX_W   = 3;
    localparam int ZERO_IDX = 6;
    localparam int PC_IDX   = 7;

    localparam logic [3:0] OP_MOV = 4'd0;
    localparam logic [3:0] OP_ADD = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_CMP = 4'd3;
    localparam logic [3:0] OP_JMP = 4'd4;
    localparam logic [3:0] OP_JE  = 4'd5;
    localparam logic [3:0] OP_LD  = 4'd6;
    localparam logic [3:0] OP_ST  = 4'd7;
    localparam logic [3:0] OP_HLT = 4'd15;

    typedef enum logic {
        FN_ADD = 1'b0,
        FN_AND = 1'b1
    } alu_fn_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rx;
        logic [RIDX_W-1:0] ry;
        logic              use_imm;
        logic [IMM_W-1:0]  imm;
        alu_fn_e           fn;
        logic              x_zero;
        logic              reg_we;
        logic              load;
        logic              store;
        logic              cmp;
        logic              jmp;
        logic              je;
        logic              hlt;
    } dec_t;
endpackage

// File: rtl/tc_decode.sv
// Module tc_decode
// Purely combinational instruction decoder. Splits a 32-bit word into its
// register, immediate and control fields. Undefined opcodes decode to a
// word with no side effects, so they behave as a no-op.
module tc_decode
    import tc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [3:0] opcode;
    logic       unused_bits;

    assign opcode      = instr[31:28];
    assign unused_bits = ^{instr[27], instr[23], instr[19], instr[15:9]};

    // Extract fields and set control flags from the opcode.
    always_comb begin
        dec         = '0;
        dec.rd      = instr[26:24];
        dec.rx      = instr[22:20];
        dec.ry      = instr[18:16];
        dec.use_imm = instr[8];
        dec.imm     = instr[7:0];
        dec.fn      = FN_ADD;
        case (opcode)
            OP_MOV: begin
                dec.reg_we = 1'b1;
                dec.x_zero = 1'b1;
            end
            OP_ADD: dec.reg_we = 1'b1;
            OP_AND: begin
                dec.reg_we = 1'b1;
                dec.fn     = FN_AND;
            end
            OP_CMP: dec.cmp = 1'b1;
            OP_JMP: dec.jmp = 1'b1;
            OP_JE:  dec.je  = 1'b1;
            OP_LD: begin
                dec.reg_we = 1'b1;
                dec.load   = 1'b1;
            end
            OP_ST:  dec.store = 1'b1;
            OP_HLT: dec.hlt   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tc_alu.sv
// Module tc_alu
// Two-operand arithmetic unit: modular add or bitwise AND. The zero test
// always looks at the sum X+Y, which is what the compare instruction uses.
module tc_alu
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res,
    output logic         sum_zero
);
    logic [W-1:0] sum;

    // Choose the result and test the sum for zero.
    always_comb begin
        sum      = x + y;
        res      = (fn == FN_AND) ? (x & y) : sum;
        sum_zero = (sum == '0);
    end

    // R3: an AND result never has a bit set that is clear in either operand
    always_comb begin
        if (fn == FN_AND) begin
            p_and_subset_r3: assert ((res & ~x) == '0 && (res & ~y) == '0);
        end
    end
endmodule

// File: rtl/tc_regfile.sv
// Module tc_regfile
// Register slots with one write port and NRD combinational read ports.
// The zero slot holds no storage and reads 0. The PC slot reads the pc
// input; writes to it are handled by the next-PC logic in the top level.
module tc_regfile
    import tc_pkg::*;
#(
    parameter int W   = 8,
    parameter int NRD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] wsel,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pc,
    input  logic [RIDX_W-1:0] rsel  [NRD],
    output logic [W-1:0]      rdata [NRD]
);
    logic [W-1:0] slot [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == ZERO_IDX) begin : g_zero
            assign slot[i] = '0;
        end else if (i == PC_IDX) begin : g_pc
            assign slot[i] = pc;
        end else begin : g_gpr
            logic [W-1:0] q;
            // Hold one general-purpose register; clear it on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && wsel == RIDX_W'(i))
                    q <= wdata;
            end
            assign slot[i] = q;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_read
        assign rdata[p] = slot[rsel[p]];
    end
endmodule

// File: rtl/tc_core.sv
// Module tc_core
// Single-cycle processor top. It fetches from the program store at the PC,
// decodes, reads operands, computes in the ALU and commits everything on
// one clock edge. Assumes the program is loaded while rst_n is low, and
// that W is at least the immediate width.
module tc_core
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [W-1:0]       prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    output logic               halted,
    input  logic [RIDX_W-1:0]  dbg_reg_sel,
    output logic [W-1:0]       dbg_reg_data,
    input  logic [W-1:0]       dbg_mem_addr,
    output logic [W-1:0]       dbg_mem_data
);
    localparam int DEPTH = 1 << W;
    localparam int NRD   = 4;

    logic [INSTR_W-1:0] imem [DEPTH];
    logic [W-1:0]       dmem [DEPTH];

    logic [W-1:0]      pc, pc_next;
    logic              flag;
    logic              halt_q;
    dec_t              d;
    logic [RIDX_W-1:0] rsel  [NRD];
    logic [W-1:0]      rdata [NRD];
    logic [W-1:0]      opx, opy, alu_res, wdata;
    logic              sum_zero, active, take_jump, rf_we;

    assign halted = halt_q;
    assign active = !halt_q;

    // Program store write port, used while the core is held in reset.
    always_ff @(posedge clk) begin
        if (prog_we)
            imem[prog_addr] <= prog_data;
    end

    tc_decode u_dec (
        .instr (imem[pc]),
        .dec   (d)
    );

    assign rsel[0] = d.rx;
    assign rsel[1] = d.ry;
    assign rsel[2] = d.rd;
    assign rsel[3] = dbg_reg_sel;

    tc_regfile #(.W(W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wsel  (d.rd),
        .wdata (wdata),
        .pc    (pc),
        .rsel  (rsel),
        .rdata (rdata)
    );

    // Operand multiplexers: X may be forced to zero, Y may be the immediate.
    always_comb begin
        opx = d.x_zero  ? '0 : rdata[0];
        opy = d.use_imm ? W'(d.imm) : rdata[1];
    end

    tc_alu #(.W(W)) u_alu (
        .fn       (d.fn),
        .x        (opx),
        .y        (opy),
        .res      (alu_res),
        .sum_zero (sum_zero)
    );

    assign wdata        = d.load ? dmem[alu_res] : alu_res;
    assign rf_we        = active && d.reg_we && (d.rd != RIDX_W'(PC_IDX));
    assign dbg_reg_data = rdata[3];
    assign dbg_mem_data = dmem[dbg_mem_addr];

    // Data store write port, addressed by the ALU result.
    always_ff @(posedge clk) begin
        if (active && d.store)
            dmem[alu_res] <= rdata[2];
    end

    // Next-PC selection: hold, jump or step.
    always_comb begin
        take_jump = d.jmp || (d.je && flag) ||
                    (d.reg_we && d.rd == RIDX_W'(PC_IDX));
        if (!active || d.hlt)
            pc_next = pc;
        else if (take_jump)
            pc_next = wdata;
        else
            pc_next = W'(pc + 1'b1);
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end

    // Compare flag, written only by CMP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (active && d.cmp)
            flag <= sum_zero;
    end

    // Halt latch, set by HLT and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (active && d.hlt)
            halt_q <= 1'b1;
    end

    // R2: a plain instruction steps the PC by one, modulo the store depth
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !take_jump && !d.hlt) |=> pc == W'($past(pc) + 1'b1));

    // R5: a register write aimed at slot 7 lands in the PC
    p_pc_write_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !d.hlt && d.reg_we && d.rd == RIDX_W'(PC_IDX))
            |=> pc == $past(wdata));

    // R7: the flag only moves on an executed CMP
    p_flag_only_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q || !d.cmp) |=> $stable(flag));

    // R9: once halted, the PC is frozen
    p_pc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> $stable(pc));

    // R9: halted stays set until reset
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);
endmodule

// File: tb/sim_tc_core.sv
`timescale 1ns/1ps
module sim_tc_core;
    import tc_pkg::*;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_we = 1'b0;
    logic [W-1:0] prog_addr = '0;
    logic [31:0]  prog_data = '0;
    logic         halted;
    logic [2:0]   dbg_reg_sel = '0;
    logic [W-1:0] dbg_reg_data;
    logic [W-1:0] dbg_mem_addr = '0;
    logic [W-1:0] dbg_mem_data;

    int checks = 0;
    int errors = 0;

    tc_core #(.W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_we      (prog_we),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .halted       (halted),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [2:0] rd,
                                        input logic [2:0] rx, input logic [2:0] ry,
                                        input logic ui, input logic [7:0] imm);
        return {op, 1'b0, rd, 1'b0, rx, 1'b0, ry, 7'b0, ui, imm};
    endfunction

    localparam logic [3:0] OP_UNDEF8 = 4'd8;
    localparam logic [3:0] OP_UNDEFC = 4'd12;

    // Main program; expected flow noted per line.
    localparam logic [31:0] PROG [25] = '{
        enc(OP_MOV, 0, 6, 0, 1, 8'd5),                  // 0  r0=5            R3
        enc(OP_MOV, 1, 6, 0, 1, 8'd3),                  // 1  r1=3
        enc(OP_ADD, 2, 0, 1, 0, 8'd0) | 32'h0888_FE00,  // 2  r2=8, junk in ignored bits R10
        enc(OP_AND, 3, 0, 0, 1, 8'd6),                  // 3  r3=5&6=4
        enc(OP_ADD, 4, 0, 0, 1, 8'd251),                // 4  r4=0 (wrap)
        enc(OP_MOV, 6, 6, 0, 1, 8'd9),                  // 5  discarded       R4
        enc(OP_ST,  2, 6, 0, 1, 8'd16),                 // 6  mem[16]=8       R6
        enc(OP_LD,  5, 0, 0, 1, 8'd11),                 // 7  r5=mem[16]=8
        enc(OP_CMP, 0, 0, 0, 1, 8'd251),                // 8  flag=1          R7
        enc(OP_JE,  0, 6, 0, 1, 8'd12),                 // 9  taken -> 12     R8
        enc(OP_MOV, 1, 6, 0, 1, 8'd99),                 // 10 skipped
        enc(OP_HLT, 0, 0, 0, 0, 8'd0),                  // 11 skipped
        enc(OP_CMP, 0, 0, 0, 1, 8'd1),                  // 12 flag=0
        enc(OP_JE,  0, 6, 0, 1, 8'd10),                 // 13 not taken
        enc(OP_JMP, 0, 6, 0, 1, 8'd17),                 // 14 -> 17
        enc(OP_MOV, 1, 6, 0, 1, 8'd77),                 // 15 skipped
        enc(OP_HLT, 0, 0, 0, 0, 8'd0),                  // 16 skipped
        enc(OP_MOV, 7, 6, 0, 1, 8'd20),                 // 17 jump via r7     R5
        enc(OP_MOV, 1, 6, 0, 1, 8'd55),                 // 18 skipped
        enc(OP_HLT, 0, 0, 0, 0, 8'd0),                  // 19 skipped
        enc(OP_UNDEF8, 0, 6, 0, 1, 8'd200),             // 20 no-op           R2
        enc(OP_ST,  5, 6, 0, 1, 8'd17),                 // 21 mem[17]=8
        enc(OP_ADD, 5, 7, 6, 1, 8'd0),                  // 22 r5=pc=22
        enc(OP_HLT, 0, 0, 0, 0, 8'd0),                  // 23 halt            R9
        enc(OP_MOV, 0, 6, 0, 1, 8'd1)                   // 24 never runs
    };

    // Expected results: {req, kind(0 reg,1 mem), index, value}
    localparam logic [23:0] EXPV [10] = '{
        {4'd3,  4'd0, 8'd0,  8'd5},   // R3 MOV immediate
        {4'd8,  4'd0, 8'd1,  8'd3},   // R8 skipped writes left r1 alone
        {4'd10, 4'd0, 8'd2,  8'd8},   // R10 ignored bits, register ADD
        {4'd3,  4'd0, 8'd3,  8'd4},   // R3 AND
        {4'd3,  4'd0, 8'd4,  8'd0},   // R3 add wraps
        {4'd5,  4'd0, 8'd5,  8'd22},  // R5 r7 read as PC
        {4'd4,  4'd0, 8'd6,  8'd0},   // R4 zero slot
        {4'd9,  4'd0, 8'd7,  8'd23},  // R9 PC on HLT address
        {4'd6,  4'd1, 8'd16, 8'd8},   // R6 store
        {4'd6,  4'd1, 8'd17, 8'd8}    // R6 load then store
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [W-1:0] v);
        dbg_reg_sel = 3'(idx);
        #0.5;
        v = dbg_reg_data;
    endtask

    task automatic read_mem(input int a, output logic [W-1:0] v);
        dbg_mem_addr = W'(a);
        #0.5;
        v = dbg_mem_data;
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        @(negedge clk);
        prog_we   = 1'b1;
        prog_addr = W'(a);
        prog_data = w;
        @(negedge clk);
        prog_we   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_to_halt(output int cyc);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int cyc;

        // R1 reset state
        do_reset();
        check("R1 halted after reset", 32'(halted), 0);
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            check("R1 register cleared", 32'(v), 0);
        end

        // Main program table walk
        for (int i = 0; i < 25; i++) put_word(i, PROG[i]);
        run_to_halt(cyc);
        check("R2 one instruction per cycle (cycles to halt)", 32'(cyc), 18);
        check("R9 halted raised", 32'(halted), 1);
        for (int i = 0; i < 10; i++) begin
            string tag;
            tag = $sformatf("R%0d table entry %0d", EXPV[i][23:20], i);
            if (EXPV[i][19:16] == 4'd0) read_reg(int'(EXPV[i][15:8]), v);
            else read_mem(int'(EXPV[i][15:8]), v);
            check(tag, 32'(v), 32'(EXPV[i][7:0]));
        end

        // R9 freeze after halt
        repeat (6) @(negedge clk);
        read_reg(7, v);
        check("R9 PC frozen", 32'(v), 23);
        read_reg(0, v);
        check("R9 no write after halt", 32'(v), 5);
        check("R9 halted sticky", 32'(halted), 1);

        // R1 reset clears state left by the run
        do_reset();
        check("R1 halted cleared", 32'(halted), 0);
        read_reg(7, v);
        check("R1 PC cleared", 32'(v), 0);
        read_reg(2, v);
        check("R1 r2 cleared", 32'(v), 0);

        // R7 set the flag, then show reset clears it for JE
        put_word(0, enc(OP_CMP, 0, 6, 0, 1, 8'd0));
        put_word(1, enc(OP_HLT, 0, 0, 0, 0, 8'd0));
        run_to_halt(cyc);
        read_reg(0, v);
        check("R7 CMP writes no register", 32'(v), 0);
        do_reset();
        put_word(0, enc(OP_JE, 0, 6, 0, 1, 8'd5));
        put_word(1, enc(OP_MOV, 0, 6, 0, 1, 8'd1));
        put_word(2, enc(OP_HLT, 0, 0, 0, 0, 8'd0));
        run_to_halt(cyc);
        read_reg(0, v);
        check("R8 JE not taken after reset cleared flag", 32'(v), 1);
        read_reg(7, v);
        check("R8 PC after untaken JE path", 32'(v), 2);

        // R2 PC wrap through undefined opcodes
        do_reset();
        for (int i = 0; i < 256; i++) put_word(i, enc(OP_UNDEFC, 0, 6, 0, 1, 8'd1));
        @(negedge clk);
        rst_n = 1'b1;
        repeat (255) @(negedge clk);
        read_reg(7, v);
        check("R2 PC reaches 255", 32'(v), 255);
        @(negedge clk);
        read_reg(7, v);
        check("R2 PC wraps to 0", 32'(v), 0);
        read_reg(0, v);
        check("R2 undefined opcode writes nothing", 32'(v), 0);
        check("R2 undefined opcode does not halt", 32'(halted), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule